// File: doc/BRIEF.md
# Sub-Block Cache with Critical-Word-First Refill

A direct-mapped read/write cache that sits between a processor port and a slower word-serial memory. Each line is divided into sub-blocks, and each sub-block has its own valid flag. A read miss fetches only the one sub-block that holds the requested word. A read miss never fetches the whole line.

The refill burst begins at the requested word and wraps around inside the sub-block. The cache hands that first word to the processor in the same cycle it arrives. The remaining words of the burst are then written into the array. No new processor request is taken until the burst has finished. Writes always go to memory. The cached copy of a word is updated only when its sub-block is already present. A write miss allocates nothing.

Top module: `sbc_cache`

## Requirements
- R1: After reset no sub-block is valid, so the first read of any address starts a memory burst and is not acknowledged in the request cycle.
- R2: A word address splits as offset = bits [1:0], sub-block = bit [2], index = bits [5:3], tag = bits [15:6]. A read whose tag matches the stored tag of the indexed line, and whose sub-block is valid, is acknowledged in the request cycle with the cached word. It starts no memory read.
- R3: A read miss raises `mem_rd_start` for one cycle, in the request cycle, with `mem_rd_addr` equal to the requested address. The next request cycle after it raises no further start until the burst has ended.
- R4: The first word that memory returns is the requested word. `cpu_ack` rises in that same cycle, with `cpu_rdata` equal to `mem_rd_data`.
- R5: Burst word k (k = 0..3) is stored at offset (start offset + k) mod 4 of the same sub-block. After the fourth word, every word of that sub-block hits with memory's value.
- R6: A miss to an invalid sub-block of a line whose tag matches leaves the line's other valid sub-blocks valid.
- R7: A read miss with a different tag claims the line. Every sub-block of that line becomes invalid, and then only the refilled sub-block turns valid.
- R8: While a burst is in progress after its first word, `cpu_ack`, `mem_wr_en` and `mem_rd_start` stay low, even when a request is present.
- R9: A write is acknowledged in its request cycle, with `mem_wr_en` high and `mem_wr_addr`/`mem_wr_data` equal to the request. The cached word changes only on a hit. A write miss does not allocate.
- R10: Memory may leave idle cycles (`mem_rd_valid` low) between burst words. Such cycles store nothing and acknowledge nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Request completed this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` on a read |
| mem_rd_start | output | 1 | Start of a sub-block burst read |
| mem_rd_addr | output | 16 | Burst start (critical word) address |
| mem_rd_valid | input | 1 | A burst word is present |
| mem_rd_data | input | 32 | Burst word |
| mem_wr_en | output | 1 | Write-through strobe |
| mem_wr_addr | output | 16 | Write-through address |
| mem_wr_data | output | 32 | Write-through data |

## Verification
The assertions assume that memory answers every burst start with exactly four valid words, and that it raises `mem_rd_valid` only while a burst is open. They also assume the processor keeps its request stable until it is acknowledged. The bench memory responder answers only the start it has just seen, and it returns words in wrap order from the requested offset, with a chosen number of idle cycles between words. The bench processor changes its request only away from clock edges. While a burst is still open, it deliberately presents a write so that the stall can be observed.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;
    parameter int IDX_W  = 3;
    parameter int SUB_W  = 1;
    parameter int OFF_W  = 2;

    localparam int TAG_W = ADDR_W - IDX_W - SUB_W - OFF_W;
    localparam int LINES = 1 << IDX_W;
    localparam int SUBS  = 1 << SUB_W;
    localparam int WORDS = 1 << OFF_W;
    localparam int LOC_W = IDX_W + SUB_W + OFF_W;
    localparam int DEPTH = 1 << LOC_W;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [SUB_W-1:0] sub;
        logic [OFF_W-1:0] off;
    } addr_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [SUB_W-1:0] sub;
        logic [OFF_W-1:0] off;
    } loc_t;

    typedef enum logic {ST_IDLE, ST_FILL} fsm_t;

    function automatic logic [OFF_W-1:0] wrap_off(input logic [OFF_W-1:0] start,
                                                  input logic [OFF_W-1:0] step);
        return start + step;
    endfunction
endpackage

// File: rtl/sbc_store.sv
module sbc_store
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  addr_t             rd_addr,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [SUBS-1:0]   rd_vld,
    output logic [DATA_W-1:0] rd_word,
    input  logic              claim_en,
    input  logic [IDX_W-1:0]  claim_idx,
    input  logic [TAG_W-1:0]  claim_tag,
    input  logic              mark_en,
    input  logic [IDX_W-1:0]  mark_idx,
    input  logic [SUB_W-1:0]  mark_sub,
    input  logic              wr_en,
    input  loc_t              wr_loc,
    input  logic [DATA_W-1:0] wr_data
);
    logic [SUBS-1:0]   vld  [LINES];
    logic [TAG_W-1:0]  tags [LINES];
    logic [DATA_W-1:0] dat  [DEPTH];
    loc_t              rd_loc;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LINES; l++) begin
                vld[l]  <= '0;
                tags[l] <= '0;
            end
        end else begin
            if (claim_en) begin
                vld[claim_idx]  <= '0;
                tags[claim_idx] <= claim_tag;
            end
            if (mark_en)
                vld[mark_idx][mark_sub] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            dat[wr_loc] <= wr_data;
    end

    assign rd_loc  = '{idx: rd_addr.idx, sub: rd_addr.sub, off: rd_addr.off};
    assign rd_tag  = tags[rd_addr.idx];
    assign rd_vld  = vld[rd_addr.idx];
    assign rd_word = dat[rd_loc];

    // R1: the first cycle after reset sees every line empty
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vld[rd_addr.idx] == '0));

    // R7: a claimed line holds no valid sub-block unless one is marked at once
    a_r7_claim_clears: assert property (@(posedge clk) disable iff (rst)
        (claim_en && !mark_en) |=> (vld[$past(claim_idx)] == '0));
endmodule

// File: rtl/sbc_match.sv
module sbc_match
    import sbc_pkg::*;
(
    input  addr_t            addr,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [SUBS-1:0]  line_vld,
    output logic             tag_eq,
    output logic             hit
);
    logic [SUBS-1:0] sub_hit;

    assign tag_eq = (line_tag == addr.tag);

    for (genvar s = 0; s < SUBS; s++) begin : g_sub
        assign sub_hit[s] = tag_eq && line_vld[s] && (addr.sub == SUB_W'(s));
    end

    assign hit = |sub_hit;
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  addr_t             cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              hit,
    input  logic              tag_eq,
    input  logic [DATA_W-1:0] rd_word,
    output logic              mem_rd_start,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic              claim_en,
    output logic              mark_en,
    output logic [IDX_W-1:0]  mark_idx,
    output logic [SUB_W-1:0]  mark_sub,
    output logic              wr_en,
    output loc_t              wr_loc,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy
);
    fsm_t             state;
    addr_t            base;
    logic [OFF_W-1:0] fill_cnt;
    logic             last_word;

    assign busy      = (state == ST_FILL);
    assign last_word = (fill_cnt == OFF_W'(WORDS - 1));
    assign mark_idx  = base.idx;
    assign mark_sub  = base.sub;

    always_comb begin
        cpu_ack      = 1'b0;
        cpu_rdata    = '0;
        mem_rd_start = 1'b0;
        mem_wr_en    = 1'b0;
        claim_en     = 1'b0;
        mark_en      = 1'b0;
        wr_en        = 1'b0;
        wr_loc       = '{idx: cpu_addr.idx, sub: cpu_addr.sub, off: cpu_addr.off};
        wr_data      = cpu_wdata;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        mem_wr_en = 1'b1;
                        cpu_ack   = 1'b1;
                        wr_en     = hit;
                    end else if (hit) begin
                        cpu_ack   = 1'b1;
                        cpu_rdata = rd_word;
                    end else begin
                        mem_rd_start = 1'b1;
                        claim_en     = !tag_eq;
                    end
                end
            end
            ST_FILL: begin
                wr_loc  = '{idx: base.idx, sub: base.sub, off: wrap_off(base.off, fill_cnt)};
                wr_data = mem_rd_data;
                if (mem_rd_valid) begin
                    wr_en = 1'b1;
                    if (fill_cnt == '0) begin
                        cpu_ack   = 1'b1;
                        cpu_rdata = mem_rd_data;
                    end
                    mark_en = last_word;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            base     <= '0;
            fill_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (mem_rd_start) begin
                        state    <= ST_FILL;
                        base     <= cpu_addr;
                        fill_cnt <= '0;
                    end
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        fill_cnt <= fill_cnt + 1'b1;
                        if (last_word)
                            state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: a burst start always opens a refill
    a_r3_start_opens_fill: assert property (@(posedge clk) disable iff (rst)
        mem_rd_start |=> busy);

    // R8: nothing new is issued to memory during a refill
    a_r8_quiet_in_fill: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!mem_wr_en && !mem_rd_start));

    // R8: at most one acknowledge per refill
    a_r8_single_ack: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(cpu_ack)) |-> !cpu_ack);

    // R5: the fourth valid word ends the refill
    a_r5_fill_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && mem_rd_valid && last_word) |=> !busy);

    // R10: an idle memory cycle leaves the refill position unchanged
    a_r10_gap_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_rd_valid) |=> (busy && $stable(fill_cnt)));
endmodule

// File: rtl/sbc_cache.sv
module sbc_cache
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_rd_start,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    addr_t             req_addr;
    logic [TAG_W-1:0]  line_tag;
    logic [SUBS-1:0]   line_vld;
    logic [DATA_W-1:0] line_word;
    logic              tag_eq;
    logic              hit;
    logic              claim_en;
    logic              mark_en;
    logic [IDX_W-1:0]  mark_idx;
    logic [SUB_W-1:0]  mark_sub;
    logic              wr_en;
    loc_t              wr_loc;
    logic [DATA_W-1:0] wr_data;
    logic              busy;

    assign req_addr    = addr_t'(cpu_addr);
    assign mem_rd_addr = cpu_addr;
    assign mem_wr_addr = cpu_addr;
    assign mem_wr_data = cpu_wdata;

    sbc_store u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (req_addr),
        .rd_tag    (line_tag),
        .rd_vld    (line_vld),
        .rd_word   (line_word),
        .claim_en  (claim_en),
        .claim_idx (req_addr.idx),
        .claim_tag (req_addr.tag),
        .mark_en   (mark_en),
        .mark_idx  (mark_idx),
        .mark_sub  (mark_sub),
        .wr_en     (wr_en),
        .wr_loc    (wr_loc),
        .wr_data   (wr_data)
    );

    sbc_match u_match (
        .addr     (req_addr),
        .line_tag (line_tag),
        .line_vld (line_vld),
        .tag_eq   (tag_eq),
        .hit      (hit)
    );

    sbc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (req_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_ack      (cpu_ack),
        .cpu_rdata    (cpu_rdata),
        .hit          (hit),
        .tag_eq       (tag_eq),
        .rd_word      (line_word),
        .mem_rd_start (mem_rd_start),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .mem_wr_en    (mem_wr_en),
        .claim_en     (claim_en),
        .mark_en      (mark_en),
        .mark_idx     (mark_idx),
        .mark_sub     (mark_sub),
        .wr_en        (wr_en),
        .wr_loc       (wr_loc),
        .wr_data      (wr_data),
        .busy         (busy)
    );

    // R2: a read acknowledged outside a refill never fetches
    a_r2_hit_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && !cpu_we && !busy) |-> !mem_rd_start);

    // R9: an acknowledged write outside a refill goes to memory
    a_r9_write_through: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && cpu_ack && !busy) |-> mem_wr_en);

    // R4: an acknowledge during a refill coincides with a returned word
    a_r4_ack_on_word: assert property (@(posedge clk) disable iff (rst)
        (busy && cpu_ack) |-> mem_rd_valid);
endmodule

// File: tb/sbc_cache_test.sv
`timescale 1ns/1ps
module sbc_cache_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        mem_rd_start;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_en;
    logic [15:0] mem_wr_addr;
    logic [31:0] mem_wr_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem_q [int];
    logic [9:0]  m_tag [8];
    bit          m_vld [8][2];

    always #4 clk = ~clk;

    sbc_cache uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .mem_rd_start(mem_rd_start),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_val(input int a);
        if (mem_q.exists(a)) return mem_q[a];
        return (32'(a) * 32'h9E3779B1) ^ 32'h0BAD0000;
    endfunction

    function automatic bit model_hit(input int a);
        int t = (a >> 6) & 10'h3FF;
        int i = (a >> 3) & 7;
        int s = (a >> 2) & 1;
        return m_vld[i][s] && (int'(m_tag[i]) == t);
    endfunction

    task automatic do_read(input int a, input int gap);
        int t = (a >> 6) & 10'h3FF;
        int i = (a >> 3) & 7;
        int s = (a >> 2) & 1;
        int off = a & 3;
        int base = a & ~3;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'(a);
        #1;
        if (model_hit(a)) begin
            chk("R2", "hit ack", 32'(cpu_ack), 32'd1);
            chk("R2", "hit data", cpu_rdata, mem_val(a));
            chk("R2", "hit fetch", 32'(mem_rd_start), 32'd0);
            @(posedge clk); #1;
            cpu_req = 1'b0;
        end else begin
            chk("R3", "miss start", 32'(mem_rd_start), 32'd1);
            chk("R3", "miss addr", 32'(mem_rd_addr), 32'(a));
            chk("R1", "miss no early ack", 32'(cpu_ack), 32'd0);
            if (int'(m_tag[i]) != t) begin
                m_tag[i] = 10'(t);
                m_vld[i][0] = 1'b0;
                m_vld[i][1] = 1'b0;
            end
            @(posedge clk); #1;
            for (int k = 0; k < 4; k++) begin
                for (int g = 0; g < ((k == 0) ? 0 : gap); g++) begin
                    @(negedge clk);
                    mem_rd_valid = 1'b0;
                    #1;
                    chk("R10", "gap no ack", 32'(cpu_ack), 32'd0);
                    chk("R8", "gap no write", 32'(mem_wr_en), 32'd0);
                    @(posedge clk); #1;
                end
                @(negedge clk);
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem_val(base + ((off + k) % 4));
                #1;
                if (k == 0) begin
                    chk("R4", "critical ack", 32'(cpu_ack), 32'd1);
                    chk("R4", "critical data", cpu_rdata, mem_val(a));
                end else begin
                    chk("R8", "stall ack", 32'(cpu_ack), 32'd0);
                    chk("R8", "stall write", 32'(mem_wr_en), 32'd0);
                    chk("R3", "no restart", 32'(mem_rd_start), 32'd0);
                end
                @(posedge clk); #1;
                if (k == 0) begin
                    cpu_we = 1'b1;
                    cpu_addr = 16'(a ^ 16'h0100);
                    cpu_wdata = 32'hDEAD_0000 | 32'(a);
                end
            end
            mem_rd_valid = 1'b0;
            cpu_req = 1'b0; cpu_we = 1'b0;
            m_vld[i][s] = 1'b1;
        end
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 16'(a); cpu_wdata = d;
        #1;
        chk("R9", "write ack", 32'(cpu_ack), 32'd1);
        chk("R9", "write strobe", 32'(mem_wr_en), 32'd1);
        chk("R9", "write addr", 32'(mem_wr_addr), 32'(a));
        chk("R9", "write data", mem_wr_data, d);
        chk("R9", "write no fetch", 32'(mem_rd_start), 32'd0);
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        mem_q[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int l = 0; l < 8; l++) begin
            m_tag[l] = '0; m_vld[l][0] = 1'b0; m_vld[l][1] = 1'b0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1", "idle ack", 32'(cpu_ack), 32'd0);
        chk("R1", "idle start", 32'(mem_rd_start), 32'd0);

        do_read(16'h0042, 0);      // R3 R4 R5 first miss
        do_read(16'h0040, 0);      // R5 wrapped words hit
        do_read(16'h0041, 0);
        do_read(16'h0043, 0);
        do_read(16'h0044, 1);      // R6 other sub-block
        do_read(16'h0042, 0);      // R6 first sub-block still valid
        do_write(16'h0041, 32'h1234_5678);
        do_read(16'h0041, 0);      // R9 write hit updated
        do_write(16'h0081, 32'hCAFE_0081);
        do_read(16'h0041, 0);      // R9 write miss did not allocate
        do_read(16'h0081, 0);      // R7 claim by new tag
        do_read(16'h0044, 0);      // R7 old sub-block gone
        do_read(16'h01FF, 2);      // R10 gaps
        do_read(16'h01FC, 0);
        for (int j = 0; j < 40; j++) begin
            if (j % 5 == 4)
                do_write((j * 53 + 7) & 16'h03FF, 32'h5000_0000 + 32'(j));
            do_read((j * 37 + 3) & 16'h03FF, j % 3);
            do_read((j * 37 + 3) & 16'h03FF, 0);
        end

        repeat (2) @(posedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule